// File: doc/BRIEF.md
# Power Monitor Interrupt Controller

This block gathers event indications from three power monitors: a supply brown-out detector, a core brown-out detector and a DC-DC converter monitor. Each monitor output is asynchronous to the block clock, so it first passes through a two-flop synchronizer. A rising edge of the synchronized level then sets a sticky event flag for that source. Software sees three views of every source: the latched event, the event gated by its enable bit, and the present synchronized level. One combined interrupt request is raised while any enabled source holds a latched event.

Software reaches the block through a small 32-bit register bus with single-cycle writes and a combinational read path. There are two registers. The control register at offset 0x0 holds one enable bit and one clear bit per source, side by side. The read-only status register at offset 0x4 packs three bits per source. The bus carries no streamed data, so it has no valid/ready handshake: a write takes effect on the clock edge where `bus_wr` is high, and `bus_rdata` always reflects the register selected by `bus_addr`.

Top module: `pwr_mon_irq`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0 and `irq` is 0.
- R2: Status bit 3k+2 (live level of source k) equals `mon_in[k]` as it was two clock edges earlier.
- R3: A 0-to-1 change of the synchronized level of source k sets status bit 3k (latched event) at the third clock edge after `mon_in[k]` rises. A level that stays high does not set the bit again.
- R4: The latched event of source k stays set until a control write with bit 2k+1 at 1. After such a write it is 0, unless a new edge arrives in the same cycle.
- R5: When a rising edge and a clear of the same source fall in the same cycle, the latched event ends up set.
- R6: Status bit 3k+1 (masked event) equals latched bit 3k ANDed with control enable bit 2k.
- R7: A write to offset 0x0 loads the enable bits from bits 0, 2 and 4 of the write data. Every other data bit is ignored for storage. A control read returns the enable bits at 0, 2 and 4 and zero in all other bits, including the clear bits.
- R8: `irq` is the OR of the three masked event bits.
- R9: The status register at offset 0x4 uses bits [8:0] only, and its upper bits read 0. Writes to offset 0x4 or to any other offset change nothing. Reads of offsets other than 0x0 and 0x4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the register at `bus_addr` |
| mon_in | input | 3 | Asynchronous monitor outputs: bit 0 supply brown-out, bit 1 core brown-out, bit 2 DC-DC monitor |
| irq | output | 1 | Combined interrupt request |

## Verification
A stuck or mistimed synchronizer stage shows at the ports as a live status bit that lags its input by the wrong number of edges. A latch that misses an edge, re-arms on a held level or loses a set-versus-clear race shows within three cycles of the input change as a wrong latched bit. A wrong enable bit shows as a masked bit or `irq` that disagrees with the latched bits in the cycle right after the control write. The bench follows every cycle with a behavioural model, so any such divergence is caught on the first clock it becomes visible.

// File: rtl/pwr_irq_pkg.sv
package pwr_irq_pkg;
  // Status view of one source, packed low to high: latched, masked, live.
  typedef struct packed {
    logic live;
    logic masked;
    logic raw;
  } src_stat_t;

  localparam int unsigned FIELDS_PER_SRC = 3;
  localparam int unsigned CTRL_BITS_PER_SRC = 2;
endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_async;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_sync = stg[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_chk
      // R2: each stage carries the previous stage one edge later
      assert_stage_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        stg[g] == $past(stg[g-1]));
    end
  endgenerate
endmodule

// File: rtl/pwr_evt_cell.sv
module pwr_evt_cell
  import pwr_irq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lvl_sync,
  input  logic      clr,
  input  logic      en,
  output src_stat_t stat
);
  logic prev_q;
  logic raw_q;
  logic rise;

  assign rise = lvl_sync & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      raw_q  <= 1'b0;
    end else begin
      prev_q <= lvl_sync;
      if (rise)     raw_q <= 1'b1;
      else if (clr) raw_q <= 1'b0;
    end
  end

  always_comb begin
    stat.raw    = raw_q;
    stat.masked = raw_q & en;
    stat.live   = lvl_sync;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> raw_q);
  assert_clear_takes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !raw_q);
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q && !clr) |=> raw_q);
endmodule

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs #(
  parameter int unsigned NSRC     = 3,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CTRL_OFS = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2*NSRC-1:0] wdata_lo,
  output logic [NSRC-1:0]   en_q,
  output logic [NSRC-1:0]   clr_pulse
);
  logic ctrl_wr;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q[k] <= 1'b0;
        else if (ctrl_wr) en_q[k] <= wdata_lo[2*k];
      end
      assign clr_pulse[k] = ctrl_wr & wdata_lo[2*k+1];
    end
  endgenerate
endmodule

// File: rtl/pwr_mon_irq.sv
module pwr_mon_irq
  import pwr_irq_pkg::*;
#(
  parameter int unsigned NSRC        = 3,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CTRL_OFS    = 0,
  parameter int unsigned STAT_OFS    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   mon_in,
  output logic              irq
);
  localparam int unsigned CW = CTRL_BITS_PER_SRC * NSRC;
  localparam int unsigned SW = FIELDS_PER_SRC * NSRC;

  logic [NSRC-1:0] lvl_sync;
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] clr_pulse;
  logic [NSRC-1:0] masked_v;
  logic [SW-1:0]   stat_vec;
  logic [CW-1:0]   ctrl_vec;
  src_stat_t       stat [NSRC];
  logic            unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CW];

  pwr_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (mon_in),
    .q_sync  (lvl_sync)
  );

  pwr_ctrl_regs #(.NSRC(NSRC), .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .wdata_lo  (bus_wdata[CW-1:0]),
    .en_q      (en_q),
    .clr_pulse (clr_pulse)
  );

  generate
    for (genvar k = 0; k < NSRC; k++) begin : g_src
      pwr_evt_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_sync (lvl_sync[k]),
        .clr      (clr_pulse[k]),
        .en       (en_q[k]),
        .stat     (stat[k])
      );
      assign stat_vec[FIELDS_PER_SRC*k +: FIELDS_PER_SRC] = stat[k];
      assign masked_v[k] = stat[k].masked;
      assign ctrl_vec[2*k]   = en_q[k];
      assign ctrl_vec[2*k+1] = 1'b0;
    end
  endgenerate

  assign irq = |masked_v;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(CTRL_OFS))      bus_rdata[CW-1:0] = ctrl_vec;
    else if (bus_addr == ADDR_W'(STAT_OFS)) bus_rdata[SW-1:0] = stat_vec;
  end

  // R6 / R8: with every enable clear no request can be raised
  assert_no_irq_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

// File: tb/tb_pwr_mon_irq.sv
module tb_pwr_mon_irq;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  mon_in = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  bit m_s1 [3];
  bit m_s2 [3];
  bit m_prev [3];
  bit m_lat [3];
  bit m_en [3];

  pwr_mon_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mon_in(mon_in), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_LIMIT && !done) begin
      fails++;
      $display("FAIL watchdog expired got %0d cycles exp below %0d", cycles, WDOG_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic compare();
    bit exp_irq = 0;
    logic [31:0] exp_ctrl = '0;
    for (int k = 0; k < 3; k++) begin
      exp_irq = exp_irq | (m_lat[k] & m_en[k]);
      exp_ctrl[2*k] = m_en[k];
    end
    chk("R8 irq", {31'b0, irq}, {31'b0, exp_irq});
    if (bus_addr == 4'h4) begin
      for (int k = 0; k < 3; k++) begin
        chk("R3 raw", {31'b0, bus_rdata[3*k]},   {31'b0, m_lat[k]});
        chk("R6 masked", {31'b0, bus_rdata[3*k+1]}, {31'b0, m_lat[k] & m_en[k]});
        chk("R2 live", {31'b0, bus_rdata[3*k+2]}, {31'b0, m_s2[k]});
      end
      chk("R9 status upper", {9'b0, bus_rdata[31:9]}, 32'h0);
    end else if (bus_addr == 4'h0) begin
      chk("R7 ctrl read", bus_rdata, exp_ctrl);
    end else begin
      chk("R9 unmapped read", bus_rdata, 32'h0);
    end
  endtask

  // Advance one clock: update the model from the inputs held this cycle.
  task automatic step();
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        m_s1[k] = 0; m_s2[k] = 0; m_prev[k] = 0; m_lat[k] = 0; m_en[k] = 0;
      end
    end else begin
      for (int k = 0; k < 3; k++) begin
        bit rise = m_s2[k] & ~m_prev[k];
        bit clr  = bus_wr && bus_addr == 4'h0 && bus_wdata[2*k+1];
        if (rise)     m_lat[k] = 1;
        else if (clr) m_lat[k] = 0;
        if (bus_wr && bus_addr == 4'h0) m_en[k] = bus_wdata[2*k];
        m_prev[k] = m_s2[k];
        m_s2[k]   = m_s1[k];
        m_s1[k]   = mon_in[k];
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic wr_ctrl(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a);
    bus_addr = a;
    #1;
  endtask

  initial begin
    step();
    step();
    rst_n = 1'b1;
    step();
    // R1: reset state
    peek(4'h4); chk("R1 status", bus_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    peek(4'h0); chk("R1 ctrl", bus_rdata, 32'h0);

    // enable source 0, raise its monitor
    wr_ctrl(4'h0, 32'h1);
    peek(4'h4);
    mon_in[0] = 1'b1;
    step(); step();
    chk("R2 live after two edges", {31'b0, bus_rdata[2]}, 32'h1);
    chk("R3 raw not yet", {31'b0, bus_rdata[0]}, 32'h0);
    step();
    chk("R3 raw on third edge", {31'b0, bus_rdata[0]}, 32'h1);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);

    // clear source 0 while its level stays high
    wr_ctrl(4'h0, 32'h3);
    peek(4'h4);
    chk("R4 cleared", {31'b0, bus_rdata[0]}, 32'h0);
    step();
    chk("R4 held level no re-set", {31'b0, bus_rdata[0]}, 32'h0);

    // source 1: edge and clear in the same cycle
    mon_in[1] = 1'b1;
    step(); step();
    wr_ctrl(4'h0, 32'h9);
    peek(4'h4);
    chk("R5 set beats clear", {31'b0, bus_rdata[3]}, 32'h1);
    chk("R6 masked off when disabled", {31'b0, bus_rdata[4]}, 32'h0);

    // all-ones control write
    wr_ctrl(4'h0, 32'hFFFF_FFFF);
    peek(4'h0);
    chk("R7 only enables stored", bus_rdata, 32'h15);
    // writes elsewhere ignored
    wr_ctrl(4'h4, 32'h0);
    wr_ctrl(4'h8, 32'h0);
    peek(4'h0);
    chk("R9 write to status ignored", bus_rdata, 32'h15);

    // random phase
    for (int i = 0; i < 1500; i++) begin
      for (int b = 0; b < 3; b++)
        if ($urandom % 5 == 0) mon_in[b] = ~mon_in[b];
      bus_wr = ($urandom % 4 == 0);
      case ($urandom % 3)
        0: bus_addr = 4'h0;
        1: bus_addr = 4'h4;
        default: bus_addr = 4'h8;
      endcase
      bus_wdata = $urandom;
      step();
    end
    bus_wr = 1'b0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule